// File: doc/BRIEF.md
# Serial Line Receiver with Error Flags

This block turns an asynchronous serial input into parallel characters. A 16x oversampling enable from an external rate generator paces it. The character format comes from four static controls: the data length (5 to 8 bits), whether a parity bit is present, the parity sense, and a sense-inversion bit. These are the same settings a matching transmitter uses to build frames. The line idles at mark (1). A character is a start bit at space (0), the data bits with the least significant bit first, an optional parity bit and a stop bit.

Each completed character is written into a one-entry receive buffer. The block raises a data-ready flag for it. Four sticky error flags record overrun, parity mismatch, a missing stop bit and a break condition. The host clears data-ready with a buffer-read strobe and clears the four error flags with a status-read strobe.

Top module: `uart_rx_line`

## Requirements
- R1: After reset, `rx_byte` is 0 and all five flags are 0.
- R2: A falling edge starts a character only if the line is still at space when it is re-sampled 8 ticks later. If the line is back at mark, the receiver returns to idle and delivers nothing.
- R3: Data bits arrive least significant bit first. `wlen` sets the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Buffer bits above the data length read as 0.
- R4: `data_ready` sets in the cycle after a character completes. It clears after a cycle with `rd_buf` high and no character completing.
- R5: When a character completes while `data_ready` is set and `rd_buf` is low, `overrun` sets and the new character replaces the old one in the buffer.
- R6: When `par_en` is 1, a parity bit follows the data. When `par_even ^ par_inv` is 0, the data bits plus the parity bit must hold an odd number of ones; when it is 1, an even number. A mismatch sets `parity_err`. When `par_en` is 0, no parity bit is expected and `parity_err` never sets.
- R7: `framing_err` sets when the stop-bit sample is at space.
- R8: `break_rx` sets when every sample of a character is at space: data, parity if enabled, and stop. Such a character is delivered as 0x00 with `framing_err` also set.
- R9: A `rd_stat` pulse clears `overrun`, `parity_err`, `framing_err` and `break_rx`, and leaves `data_ready` and `rx_byte` unchanged.
- R10: After a stop sample at space, the receiver starts no new character until the line has returned to mark. A held break therefore yields exactly one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial input, mark = 1 |
| wlen | input | 2 | Data length code, 0..3 selects 5..8 bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity sense select |
| par_inv | input | 1 | Inverts the parity sense |
| rd_buf | input | 1 | Buffer-read strobe, clears data ready |
| rd_stat | input | 1 | Status-read strobe, clears error flags |
| rx_byte | output | 8 | Received character, zero-extended |
| data_ready | output | 1 | Character waiting in the buffer |
| overrun | output | 1 | Unread character was overwritten |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Stop bit sampled at space |
| break_rx | output | 1 | All-space character seen |

## Verification
The receiver is driven with several kinds of line stimulus. Clean 8-bit and shorter characters separate correct bit order and zero-extension from shifting mistakes. Characters with a deliberately wrong parity bit, under each parity sense, tell the odd check apart from the even check and from the inverted check. A dropped stop bit is compared against a line held at space for two character times, which distinguishes a framing error from a break and also shows that a held break does not keep producing characters. A short glitch shows that start qualification works. Two back-to-back characters sent without a buffer read show overrun and check that a status read leaves data ready untouched.

// File: rtl/uart_rx_line.sv
module uart_rx_line #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_inv,
  input  logic       rd_buf,
  input  logic       rd_stat,
  output logic [7:0] rx_byte,
  output logic       data_ready,
  output logic       overrun,
  output logic       parity_err,
  output logic       framing_err,
  output logic       break_rx
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        st;
  logic [1:0] sync;
  logic [CW-1:0] cnt;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic       par_acc, seen_one;

  wire rx_s      = sync[1];
  wire at_mid    = tick16 && cnt == CW'(MID - 1);
  wire at_end    = tick16 && cnt == CW'(OSR - 1);
  wire [2:0] last_bit = 3'd4 + {1'b0, wlen};
  wire char_done = (st == S_STOP) && at_end;
  wire [7:0] data_w = shreg >> (2'd3 - wlen);
  wire par_bad   = par_en && (par_acc == (par_even ^ par_inv));
  wire stop_bad  = !rx_s;
  wire brk       = !rx_s && !seen_one;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      seen_one <= 1'b0;
    end else if (tick16) begin
      case (st)
        S_IDLE:
          if (!rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (at_mid) begin
            cnt      <= '0;
            bitn     <= '0;
            par_acc  <= 1'b0;
            seen_one <= 1'b0;
            st       <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (at_end) begin
            cnt      <= '0;
            shreg    <= {rx_s, shreg[7:1]};
            par_acc  <= par_acc ^ rx_s;
            seen_one <= seen_one | rx_s;
            if (bitn == last_bit) st <= par_en ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        S_PAR:
          if (at_end) begin
            cnt      <= '0;
            par_acc  <= par_acc ^ rx_s;
            seen_one <= seen_one | rx_s;
            st       <= S_STOP;
          end else cnt <= cnt + 1'b1;
        S_STOP:
          if (at_end) begin
            cnt <= '0;
            st  <= rx_s ? S_IDLE : S_HOLD;
          end else cnt <= cnt + 1'b1;
        S_HOLD:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      data_ready  <= 1'b0;
      overrun     <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      break_rx    <= 1'b0;
    end else if (char_done) begin
      rx_byte     <= data_w;
      data_ready  <= 1'b1;
      overrun     <= (overrun && !rd_stat) || (data_ready && !rd_buf);
      parity_err  <= (parity_err && !rd_stat) || par_bad;
      framing_err <= (framing_err && !rd_stat) || stop_bad;
      break_rx    <= (break_rx && !rd_stat) || brk;
    end else begin
      if (rd_buf) data_ready <= 1'b0;
      if (rd_stat) begin
        overrun     <= 1'b0;
        parity_err  <= 1'b0;
        framing_err <= 1'b0;
        break_rx    <= 1'b0;
      end
    end
  end

  AST_DR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> data_ready); // R4
  AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_buf && !char_done |=> !data_ready); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && data_ready && !rd_buf |=> overrun); // R5
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !char_done |=> !overrun && !parity_err && !framing_err && !break_rx); // R9
  AST_STAT_KEEP_DR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !rd_buf && !char_done |=> data_ready == $past(data_ready) && $stable(rx_byte)); // R9
  AST_BRK_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
    break_rx |-> framing_err); // R8
  AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && wlen == 2'b00 |=> rx_byte[7:5] == 3'b000); // R3
  AST_NO_PAR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && !par_en && !parity_err |=> !parity_err); // R6
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_HOLD && !rx_s |=> st == S_HOLD); // R10
endmodule

// File: tb/uart_rx_line_bench.sv
module uart_rx_line_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, par_inv = 1'b0;
  logic rd_buf = 1'b0, rd_stat = 1'b0;
  logic [7:0] rx_byte;
  logic data_ready, overrun, parity_err, framing_err, break_rx;

  int n_run = 0, n_fail = 0, n_push = 0, n_pop = 0;
  bit done = 0;
  logic [10:0] expq[$];
  logic dr_q = 1'b0;
  logic [2:0] tdiv = '0;

  uart_rx_line u_uart_rx_line (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_inv(par_inv),
    .rd_buf(rd_buf), .rd_stat(rd_stat), .rx_byte(rx_byte),
    .data_ready(data_ready), .overrun(overrun), .parity_err(parity_err),
    .framing_err(framing_err), .break_rx(break_rx));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3'd3) ? 3'd0 : tdiv + 3'd1;
    tick16 <= (tdiv == 3'd3);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && data_ready && !dr_q) begin
      if (expq.size() == 0) check(0, "R4 unexpected char", {24'd0, rx_byte}, 32'd0);
      else begin
        logic [10:0] e;
        e = expq.pop_front();
        n_pop++;
        check({rx_byte, parity_err, framing_err, break_rx} == e, "R3/R6/R7/R8 scoreboard",
              {21'd0, rx_byte, parity_err, framing_err, break_rx}, {21'd0, e});
      end
    end
    dr_q <= data_ready;
  end

  task automatic bit_time(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  function automatic logic good_par(input logic [7:0] d);
    return (^d) ^ ~(par_even ^ par_inv);
  endfunction

  task automatic send_char(input logic [7:0] d, input bit bad_par, input logic stopv, input bit push);
    int nb;
    logic [7:0] m;
    logic pb;
    nb = 5 + int'(wlen);
    m  = d & ((8'd1 << nb) - 8'd1);
    pb = good_par(m) ^ bad_par;
    if (push) begin
      expq.push_back({m, par_en & bad_par, ~stopv,
                      (m == 8'd0) && !stopv && (!par_en || !pb)});
      n_push++;
    end
    @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) bit_time(d[i]);
    if (par_en) bit_time(pb);
    bit_time(stopv);
    if (!stopv) bit_time(1'b1);
    repeat (20) @(negedge clk);
  endtask

  task automatic read_both();
    @(negedge clk); rd_buf = 1'b1; rd_stat = 1'b1;
    @(negedge clk); rd_buf = 1'b0; rd_stat = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(rx_byte == 8'd0 && {data_ready, overrun, parity_err, framing_err, break_rx} == 5'd0,
          "R1 reset", {19'd0, rx_byte, data_ready, overrun, parity_err, framing_err, break_rx}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R3 R4: 8N1
    send_char(8'hA5, 0, 1'b1, 1);
    check(data_ready == 1'b1, "R4 dr set", data_ready, 1);
    @(negedge clk); rd_buf = 1'b1; @(negedge clk); rd_buf = 1'b0;
    check(data_ready == 1'b0, "R4 dr clear", data_ready, 0);
    send_char(8'h3C, 0, 1'b1, 1); read_both();

    // R3: short lengths
    wlen = 2'd0; send_char(8'hF5, 0, 1'b1, 1); read_both();
    wlen = 2'd1; send_char(8'hEA, 0, 1'b1, 1); read_both();
    wlen = 2'd2; send_char(8'hD9, 0, 1'b1, 1); read_both();
    wlen = 2'd3;

    // R6: parity senses
    par_en = 1'b1;
    send_char(8'h37, 0, 1'b1, 1); read_both();
    send_char(8'h37, 1, 1'b1, 1);
    check(parity_err == 1'b1, "R6 odd mismatch", parity_err, 1);
    @(negedge clk); rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
    check(parity_err == 1'b0 && data_ready == 1'b1, "R9 stat read clears pe only",
          {parity_err, data_ready}, 2'b01);
    read_both();
    par_even = 1'b1;
    send_char(8'h81, 0, 1'b1, 1); read_both();
    send_char(8'h81, 1, 1'b1, 1); read_both();
    par_inv = 1'b1;
    send_char(8'h81, 0, 1'b1, 1); read_both();
    send_char(8'h07, 1, 1'b1, 1); read_both();
    par_even = 1'b0; par_inv = 1'b0; par_en = 1'b0;
    send_char(8'h80, 0, 1'b1, 1);
    check(parity_err == 1'b0, "R6 no parity", parity_err, 0);
    read_both();

    // R7: framing
    send_char(8'h5A, 0, 1'b0, 1);
    check(framing_err == 1'b1 && break_rx == 1'b0, "R7 framing", {framing_err, break_rx}, 2'b10);
    read_both();

    // R8 R10: held break
    expq.push_back({8'h00, 1'b0, 1'b1, 1'b1}); n_push++;
    @(negedge clk);
    rxd = 1'b0; repeat (1400) @(negedge clk);
    check(data_ready == 1'b1 && break_rx == 1'b1, "R8 break", {data_ready, break_rx}, 2'b11);
    @(negedge clk); rd_buf = 1'b1; @(negedge clk); rd_buf = 1'b0;
    repeat (800) @(negedge clk);
    check(data_ready == 1'b0, "R10 no repeat char in break", data_ready, 0);
    rxd = 1'b1; repeat (200) @(negedge clk);
    read_both();
    check(break_rx == 1'b0 && framing_err == 1'b0, "R9 clears break", {break_rx, framing_err}, 0);

    // R2: glitch
    @(negedge clk); rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (900) @(negedge clk);
    check(data_ready == 1'b0, "R2 false start", data_ready, 0);
    send_char(8'h69, 0, 1'b1, 1); read_both();

    // R5 R9: overrun
    send_char(8'h11, 0, 1'b1, 1);
    send_char(8'h22, 0, 1'b1, 0);
    check(overrun == 1'b1 && rx_byte == 8'h22, "R5 overrun", {overrun, rx_byte}, {1'b1, 8'h22});
    @(negedge clk); rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0;
    check(overrun == 1'b0 && data_ready == 1'b1 && rx_byte == 8'h22, "R9 stat keeps dr",
          {overrun, data_ready, rx_byte}, {2'b01, 8'h22});
    read_both();

    check(n_pop == n_push && expq.size() == 0, "R4 all chars delivered", n_pop, n_push);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule